// File: doc/BRIEF.md
# Selectable-Order Delta-Sigma Fraction Modulator

This block produces the per-reference-cycle division ratio for a fractional-N feedback divider. It receives a 16-bit integer divide value and a 25-bit fraction. On every clock, which stands for one comparison cycle, it issues an integer ratio. Averaged over many cycles, that ratio equals the integer plus fraction / 2^25. The quantisation noise is shaped by a cascade of up to four 25-bit accumulators. Their carries are merged through difference networks, so the issued ratio wanders around the integer value while its mean stays exact.

The number of active accumulators, and so the noise-shaping order, is picked at run time with a 2-bit code. A dither bit may be injected into the first accumulator to break up idle tones. That bit either comes from a free-running shift-register sequence or is a fixed 1 on every cycle. When fractional operation is switched off, the block issues the integer value unchanged. Third order with pseudo-random dither is the intended working point.

Top module: `sdm_frac_modulator`

## Requirements
- R1: While `rst` is high, `div_out` is 0, all accumulators and difference-network history registers are 0, and the dither sequence register holds the value 1.
- R2: When `frac_en` is 0 at a clock edge, `div_out` after that edge equals `{1'b0, int_val}`, whatever `frac_val`, `order_sel`, `dith_en` and `dith_const` are.
- R3: `div_out` is registered. Its value after edge n depends only on the inputs sampled at edge n and the state built up before it. It equals `int_val + y` modulo 2^17, with `y` a signed noise-shaped offset.
- R4: `order_sel` selects the order as follows: 2'b00 gives first order, 2'b01 second, 2'b10 third and 2'b11 fourth. Stage k (1..4) is active when k <= `order_sel` + 1. Inactive stages keep zero residue and produce no carry.
- R5: On each edge, stage 1 adds `frac_val` plus the dither bit to its 25-bit residue. Each later active stage adds the new residue of the stage before it to its own residue. Each stage's carry is bit 25 of its sum. The offset is built from the deepest stage upward: t5 = 0, and t_k = c_k + t_{k+1} - (t_{k+1} of the previous cycle). The offset `y` is t1.
- R6: At order N, the offset `y` stays within 1 - 2^(N-1) to 2^(N-1). For example, third order gives -3 to +4.
- R7: At first order with dither off, starting from cleared state with `frac_val` = 2^22, exactly 8 of the following 64 cycles issue `int_val + 1`, and the rest issue `int_val`.
- R8: The pseudo-random dither source is a 23-bit register s that advances on every edge out of reset: s <= {s[21:0], s[22] ^ s[17]}. When `dith_en` = 1 and `dith_const` = 0, the injected bit is s[0] of the value held before the edge.
- R9: When `dith_en` = 1 and `dith_const` = 1, a 1 is added to the stage 1 input on every cycle. When `dith_en` = 0, nothing is injected and `dith_const` has no effect.
- R10: With `frac_en` = 1, a change of `frac_val` or `order_sel` from the value sampled on the previous edge clears every accumulator and history register on that edge. On that edge `div_out` becomes exactly `{1'b0, int_val}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_en | input | 1 | 1 enables fractional operation, 0 passes the integer through |
| order_sel | input | 2 | Modulator order code (00 first .. 11 fourth) |
| dith_en | input | 1 | Enables dither injection |
| dith_const | input | 1 | Dither source: 0 pseudo-random, 1 constant one |
| int_val | input | 16 | Integer part of the divide value |
| frac_val | input | 25 | Fractional part, in units of 2^-25 |
| div_out | output | 17 | Instantaneous division ratio for this cycle |

## Verification
The bench targets the cycle where the fraction or the order changes. A design that failed to clear there would keep stale residues, and the very next ratio would come out off the integer. It compares every order against a cycle-exact model over long runs. A wrong difference network shows up as a shifted or out-of-range offset, and if the deeper stages were not held at zero at low orders, carries would leak into the result. A counted first-order window checks the exact carry density, which would catch an off-by-one in the carry bit position. Runs with constant, pseudo-random and disabled dither catch a dither bit injected at the wrong stage or taken from the wrong sequence phase.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int unsigned FRAC_W    = 25;
    localparam int unsigned INT_W     = 16;
    localparam int unsigned MAX_ORDER = 4;
    localparam int unsigned ORD_W     = $clog2(MAX_ORDER);
    localparam int unsigned SHAPE_W   = 6;
    localparam int unsigned OUT_W     = INT_W + 1;
    localparam int unsigned LFSR_W    = 23;
    localparam int unsigned LFSR_TAP  = 17;
    localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

    typedef logic signed [SHAPE_W-1:0] shape_t;

    typedef enum logic [ORD_W-1:0] {
        ORD_FIRST  = 2'b00,
        ORD_SECOND = 2'b01,
        ORD_THIRD  = 2'b10,
        ORD_FOURTH = 2'b11
    } order_e;

    typedef struct packed {
        logic              carry;
        logic [FRAC_W-1:0] residue;
    } stage_out_t;

    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP]};
    endfunction

    function automatic logic stage_enabled(input order_e o, input int unsigned idx);
        return idx <= (int'(o) + 1);
    endfunction

    function automatic shape_t shape_lo(input order_e o);
        return shape_t'(1 - (1 << int'(o)));
    endfunction

    function automatic shape_t shape_hi(input order_e o);
        return shape_t'(1 << int'(o));
    endfunction

endpackage

// File: rtl/sdm_dither_gen.sv
module sdm_dither_gen
    import sdm_pkg::*;
#(
    parameter int unsigned W   = LFSR_W,
    parameter int unsigned TAP = LFSR_TAP
) (
    input  logic clk,
    input  logic rst,
    input  logic dith_en,
    input  logic dith_const,
    output logic dbit
);
    logic [W-1:0] seq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= W'(1);
        end else begin
            seq_q <= {seq_q[W-2:0], seq_q[W-1] ^ seq_q[TAP]};
        end
    end

    always_comb begin
        dbit = dith_en & (dith_const | seq_q[0]);
    end

    // A maximal-length sequence never reaches the all-zero lock-up state.
    p_seq_live_r8: assert property (@(posedge clk) disable iff (rst)
        seq_q != '0);

    // The register only shifts: the upper bits follow the lower bits of the previous cycle.
    p_seq_shift_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> seq_q[W-1:1] == $past(seq_q[W-2:0]));

endmodule

// File: rtl/sdm_accum_stage.sv
module sdm_accum_stage
    import sdm_pkg::*;
#(
    parameter int unsigned W = FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         clear,
    input  logic [W-1:0] addend,
    input  logic         cin,
    output stage_out_t   so
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    always_comb begin
        sum        = {1'b0, acc_q} + {1'b0, addend} + {{W{1'b0}}, cin};
        so.carry   = active & sum[W];
        so.residue = active ? sum[W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !active) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[W-1:0];
        end
    end

    // A stage that wakes up (order raised) starts from an empty residue.
    p_wake_empty_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> acc_q == '0);

    // After a clear the residue is empty on the following cycle.
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc_q == '0);

endmodule

// File: rtl/sdm_shape_cell.sv
module sdm_shape_cell
    import sdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   carry,
    input  shape_t t_up,
    input  shape_t t_up_prev,
    output shape_t t_out,
    output shape_t t_prev
);
    always_comb begin
        t_out = shape_t'({{(SHAPE_W-1){1'b0}}, carry}) + t_up - t_up_prev;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            t_prev <= '0;
        end else begin
            t_prev <= t_out;
        end
    end

    // The history register is exactly one cycle behind the cell output.
    p_history_lag_r5: assert property (@(posedge clk) disable iff (rst)
        !clear |=> t_prev == $past(t_out));

endmodule

// File: rtl/sdm_frac_modulator.sv
module sdm_frac_modulator
    import sdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frac_en,
    input  logic [ORD_W-1:0]     order_sel,
    input  logic                 dith_en,
    input  logic                 dith_const,
    input  logic [INT_W-1:0]     int_val,
    input  logic [FRAC_W-1:0]    frac_val,
    output logic [OUT_W-1:0]     div_out
);
    order_e             ord;
    order_e             ord_q;
    logic [FRAC_W-1:0]  frac_q;
    logic               chg;
    logic               clear;
    logic               dbit;
    logic [MAX_ORDER:1] act;

    stage_out_t         so_arr [1:MAX_ORDER];
    logic [FRAC_W-1:0]  res    [0:MAX_ORDER];
    shape_t             t_sig  [1:MAX_ORDER+1];
    shape_t             t_hist [2:MAX_ORDER+1];
    logic [OUT_W-1:0]   int_ext;
    logic [OUT_W-1:0]   off_ext;

    assign ord     = order_e'(order_sel);
    assign chg     = frac_en && ((frac_val != frac_q) || (ord != ord_q));
    assign clear   = !frac_en || chg;
    assign res[0]  = frac_val;
    assign int_ext = {1'b0, int_val};

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            ord_q  <= ORD_FIRST;
        end else begin
            frac_q <= frac_val;
            ord_q  <= ord;
        end
    end

    sdm_dither_gen #(.W(LFSR_W), .TAP(LFSR_TAP)) u_dither (
        .clk       (clk),
        .rst       (rst),
        .dith_en   (dith_en),
        .dith_const(dith_const),
        .dbit      (dbit)
    );

    for (genvar k = 1; k <= MAX_ORDER; k++) begin : g_stage
        logic cin_k;
        if (k == 1) begin : g_head
            assign cin_k = dbit;
        end else begin : g_tail
            assign cin_k = 1'b0;
        end

        assign act[k] = frac_en && stage_enabled(ord, k);

        sdm_accum_stage #(.W(FRAC_W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .active(act[k]),
            .clear (clear),
            .addend(res[k-1]),
            .cin   (cin_k),
            .so    (so_arr[k])
        );

        assign res[k] = so_arr[k].residue;

        // Stages above the selected order stay silent.
        p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
            !act[k] |-> (so_arr[k] == '0));
    end

    assign t_sig[MAX_ORDER+1]  = '0;
    assign t_hist[MAX_ORDER+1] = '0;

    for (genvar k = 2; k <= MAX_ORDER; k++) begin : g_shape
        sdm_shape_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .clear    (clear),
            .carry    (so_arr[k].carry),
            .t_up     (t_sig[k+1]),
            .t_up_prev(t_hist[k+1]),
            .t_out    (t_sig[k]),
            .t_prev   (t_hist[k])
        );
    end

    assign t_sig[1] = shape_t'({{(SHAPE_W-1){1'b0}}, so_arr[1].carry}) + t_sig[2] - t_hist[2];
    assign off_ext  = {{(OUT_W-SHAPE_W){t_sig[1][SHAPE_W-1]}}, t_sig[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= '0;
        end else if (clear) begin
            div_out <= int_ext;
        end else begin
            div_out <= int_ext + off_ext;
        end
    end

    // Integer mode passes the integer through one edge later.
    p_bypass_int_r2: assert property (@(posedge clk) disable iff (rst)
        !frac_en |=> div_out == $past(int_ext));

    // A settings change yields the plain integer on that edge.
    p_change_clear_r10: assert property (@(posedge clk) disable iff (rst)
        chg |=> div_out == $past(int_ext));

    // Offset stays inside the span the selected order allows.
    p_offset_span_r6: assert property (@(posedge clk) disable iff (rst)
        (frac_en && !chg) |-> (t_sig[1] >= shape_lo(ord)) && (t_sig[1] <= shape_hi(ord)));

endmodule

// File: tb/sdm_frac_modulator_tb.sv
`timescale 1ns/1ps
module sdm_frac_modulator_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        frac_en;
    logic [1:0]  order_sel;
    logic        dith_en;
    logic        dith_const;
    logic [15:0] int_val;
    logic [24:0] frac_val;
    logic [16:0] div_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sdm_frac_modulator u_dut (
        .clk       (clk),
        .rst       (rst),
        .frac_en   (frac_en),
        .order_sel (order_sel),
        .dith_en   (dith_en),
        .dith_const(dith_const),
        .int_val   (int_val),
        .frac_val  (frac_val),
        .div_out   (div_out)
    );

    // ---------------- reference model ----------------
    longint      m_acc  [1:4];
    int          m_hist [2:5];
    logic [22:0] m_seq;
    logic [24:0] m_frac_q;
    logic [1:0]  m_ord_q;

    function automatic void model_reset();
        for (int k = 1; k <= 4; k++) m_acc[k] = 0;
        for (int k = 2; k <= 5; k++) m_hist[k] = 0;
        m_seq    = 23'd1;
        m_frac_q = '0;
        m_ord_q  = 2'b00;
    endfunction

    function automatic int model_step(input bit en, input logic [1:0] ord,
                                      input bit den, input bit dc,
                                      input logic [24:0] fv);
        bit     chg;
        int     dbit;
        int     c [1:4];
        int     t [1:5];
        longint in_v;
        longint s;
        int     y;
        chg  = en && ((fv != m_frac_q) || (ord != m_ord_q));
        dbit = den ? (dc ? 1 : int'(m_seq[0])) : 0;
        m_frac_q = fv;
        m_ord_q  = ord;
        m_seq    = {m_seq[21:0], m_seq[22] ^ m_seq[17]};
        if (!en || chg) begin
            for (int k = 1; k <= 4; k++) m_acc[k] = 0;
            for (int k = 2; k <= 5; k++) m_hist[k] = 0;
            return 0;
        end
        in_v = longint'(fv) + dbit;
        for (int k = 1; k <= 4; k++) begin
            if (k <= int'(ord) + 1) begin
                s        = m_acc[k] + in_v;
                c[k]     = int'(s >> 25);
                m_acc[k] = s & 64'h1FF_FFFF;
                in_v     = m_acc[k];
            end else begin
                c[k]     = 0;
                m_acc[k] = 0;
            end
        end
        t[5] = 0;
        for (int k = 4; k >= 1; k--) t[k] = c[k] + t[k+1] - m_hist[k+1];
        for (int k = 2; k <= 4; k++) m_hist[k] = t[k];
        y = t[1];
        return y;
    endfunction

    task automatic check(input string tag, input logic [16:0] exp);
        n_vec++;
        if (div_out !== exp) begin
            n_bad++;
            $display("FAIL %s: div_out=%0d expected=%0d at %0t", tag, div_out, exp, $time);
        end
    endtask

    // Applies inputs after a falling edge; the next rising edge consumes them,
    // the following falling edge is where the registered result is sampled.
    task automatic step(input string tag, input bit en, input logic [1:0] ord,
                        input bit den, input bit dc, input logic [15:0] iv,
                        input logic [24:0] fv, output int y);
        logic [16:0] exp;
        frac_en = en; order_sel = ord; dith_en = den; dith_const = dc;
        int_val = iv; frac_val = fv;
        y   = model_step(en, ord, den, dc, fv);
        exp = 17'(int'(iv) + y);
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic span_check(input string tag, input logic [1:0] ord, input int y);
        int lo;
        int hi;
        lo = 1 - (1 << ord);
        hi = 1 << ord;
        n_vec++;
        if (y < lo || y > hi) begin
            n_bad++;
            $display("FAIL %s: offset=%0d expected within %0d..%0d", tag, y, lo, hi);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int y;
        int ysum;
        int seed;
        logic [24:0] fv;
        logic [15:0] iv;
        logic [1:0]  ord;
        seed = 32'h5d3a_91c7;
        void'($urandom(seed));

        rst = 1'b1; frac_en = 0; order_sel = 0; dith_en = 0; dith_const = 0;
        int_val = 16'd500; frac_val = 25'h123_4567;
        repeat (3) @(negedge clk);
        check("R1 reset output", 17'd0);
        rst = 1'b0;
        model_reset();

        // R2: integer mode ignores fraction, order and dither settings
        for (int i = 0; i < 40; i++) begin
            step("R2 integer pass-through", 1'b0, 2'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom), 25'($urandom), y);
        end

        // R7: first-order carry density, dither off; first edge clears (R10)
        step("R10 clear on fraction change", 1'b1, 2'b00, 1'b0, 1'b0, 16'd100, 25'h040_0000, y);
        ysum = 0;
        for (int i = 0; i < 64; i++) begin
            step("R3 first-order cycle", 1'b1, 2'b00, 1'b0, 1'b0, 16'd100, 25'h040_0000, y);
            ysum += int'(div_out) - 100;
        end
        n_vec++;
        if (ysum != 8) begin
            n_bad++;
            $display("FAIL R7: carries over 64 cycles=%0d expected=8", ysum);
        end

        // R4/R5/R6/R8: every order with pseudo-random dither
        for (int o = 0; o < 4; o++) begin
            fv = 25'($urandom);
            iv = 16'(1000 + $urandom_range(0, 60000));
            for (int i = 0; i < 400; i++) begin
                step("R4 R8 order sweep, random dither", 1'b1, 2'(o), 1'b1, 1'b0, iv, fv, y);
                span_check("R6 offset span", 2'(o), int'(div_out) - int'(iv));
            end
        end

        // R9: constant dither at third order, then dither disabled with mode toggling
        fv = 25'h000_0000;
        for (int i = 0; i < 200; i++)
            step("R9 constant dither", 1'b1, 2'b10, 1'b1, 1'b1, 16'd2000, fv, y);
        fv = 25'h155_5555;
        for (int i = 0; i < 200; i++)
            step("R9 dither off ignores mode", 1'b1, 2'b10, 1'b0, 1'($urandom), 16'd2000, fv, y);

        // R10: explicit change points
        for (int i = 0; i < 30; i++)
            step("R5 steady third order", 1'b1, 2'b10, 1'b1, 1'b0, 16'd3000, 25'h0AB_CDEF, y);
        step("R10 fraction change", 1'b1, 2'b10, 1'b1, 1'b0, 16'd3000, 25'h0AB_CDF0, y);
        if (div_out !== 17'd3000) begin
            n_bad++;
            $display("FAIL R10: div_out=%0d expected=3000 after fraction change", div_out);
        end
        n_vec++;
        for (int i = 0; i < 20; i++)
            step("R5 steady after clear", 1'b1, 2'b10, 1'b1, 1'b0, 16'd3000, 25'h0AB_CDF0, y);
        step("R10 order change", 1'b1, 2'b11, 1'b1, 1'b0, 16'd3000, 25'h0AB_CDF0, y);
        if (div_out !== 17'd3000) begin
            n_bad++;
            $display("FAIL R10: div_out=%0d expected=3000 after order change", div_out);
        end
        n_vec++;

        // Extreme fraction at fourth order
        for (int i = 0; i < 200; i++) begin
            step("R6 full-scale fraction", 1'b1, 2'b11, 1'b1, 1'b1, 16'd400, 25'h1FF_FFFF, y);
            span_check("R6 offset span full scale", 2'b11, int'(div_out) - 400);
        end

        // Constrained random mix
        ord = 2'b10; fv = 25'($urandom); iv = 16'd5000;
        for (int i = 0; i < 4000; i++) begin
            bit en;
            if ($urandom_range(0, 49) == 0) fv  = 25'($urandom);
            if ($urandom_range(0, 79) == 0) ord = 2'($urandom);
            if ($urandom_range(0, 29) == 0) iv  = 16'(64 + $urandom_range(0, 65000));
            en = ($urandom_range(0, 99) != 0);
            step("R3 R5 random mix", en, ord, 1'($urandom), 1'($urandom), iv, fv, y);
        end

        finish_run();
    end

endmodule